// File: doc/BRIEF.md
# Indexed Programmable Clock Generator Bank

This block holds a set of clock generators that share one small register window. Software selects a generator by writing its number into the low byte of either the generator control word or the generator divide word. Every later full-word read of those two words shows the fields of the selected generator. A full-word write carries its own generator number and updates that generator.

Each generator picks one of several source tick inputs. Every pulse on a tick input stands for one edge of a source clock, so a source clock period is two ticks. The generator divides the source in one of two ways. The integer mode divides by the programmed value and can optionally even out the duty cycle for odd values. The power-of-two mode divides by 2^(value+1).

A generator that is disabled holds its output at a programmable off level. The enable is gated glitch-free: the output only starts or stops at the off level. Configuration writes reach the generators through a fixed synchronisation delay, and a busy flag covers that delay. A self-clearing soft reset returns every generator to its defaults. After any reset, generator 0 runs undivided from source 0.

Top module: `clkgen_bank`

## Requirements
- R1: After reset, generator 0 is enabled with source 0, integer mode and divide value 0. Every other generator is disabled with off level 0 and output enable 0. The selected generator is 0, and reads of the status word (address 1) return bit 0 = 0.
- R2: A write with byte enables 4'b0001 to the control word (address 2) or the divide word (address 3) selects the generator numbered in bits 3:0 and changes no field. A later read of address 2 returns that number in bits 3:0 and its fields: source in 11:8, enable in 16, duty-improve in 17, off level in 18, output enable in 19, power mode in 20. A read of address 3 returns the number in bits 3:0 and the divide value in bits 15:8.
- R3: In integer mode with divide value N > 1 and duty-improve clear, the output period is 2N ticks. The output is high for N ticks when N is even and for N-1 ticks when N is odd.
- R4: In integer mode with duty-improve set, the output is high for N ticks and low for N ticks, for odd N as well as even N.
- R5: In integer mode, a divide value of 0 or 1 passes the source through: the output is high for 1 tick and low for 1 tick.
- R6: In power mode with divide value E, the output is high for 2^(E+1) ticks and low for 2^(E+1) ticks.
- R7: A stopped generator drives its output at the off level. The generator's pin output equals the generator output when output enable is 1, and is 0 otherwise.
- R8: A full-word write (byte enables 4'hF) sets the busy flag (status bit 0) for SYNC_LAT cycles. The new settings reach the generator only when busy clears. Any write made while busy is ignored.
- R9: After the enable bit is cleared, it reads back as 1 until the generator has actually stopped.
- R10: Writing 1 to bit 0 of the main word (address 0) starts a soft reset. That bit reads 1 until the reset completes and then clears itself, leaving the R1 defaults.
- R11: A generator starts and stops only at its off level, so the first high pulse after an enable has full width.
- R12: The source field selects which tick input clocks the generator. A source number with no matching input stops the ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and generator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_tick | input | NSRC | Per-source tick strobes, one per source clock edge |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Word select: 0 main, 1 status, 2 control, 3 divide |
| bus_be | input | 4 | Byte enables of the write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| gen_clk | output | NGEN | Generated clocks |
| gen_pin | output | NGEN | Pin copies of the generated clocks, gated by output enable |

## Verification
The bench measures high and low run lengths and checks that odd integer dividers with and without duty-improve come out different. A design that swapped or ignored that bit would give a symmetric (or asymmetric) wave in the wrong case. Pass-through and the power-of-two exponent offset are checked separately, because an off-by-one in the exponent doubles or halves the period.

The bench checks the enable readback right after a disable write, since a design that reported the written value would show 0 while the clock still runs. It also writes into the busy window and reads the result back, which catches a design that accepts the write and corrupts a divide value. The first pulse after an enable and the held level after a disable expose a gate that cuts a pulse short. The soft reset must clear itself and leave generator 0 running.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;
  parameter int CKG_DIV_W = 8;
  localparam int CKG_CNT_W = CKG_DIV_W + 1;

  localparam logic [1:0] A_MAIN = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_CTRL = 2'd2;
  localparam logic [1:0] A_DIV  = 2'd3;

  typedef struct packed {
    logic [3:0]           src;
    logic                 en;
    logic                 idc;
    logic                 oov;
    logic                 oe;
    logic                 divsel;
    logic [CKG_DIV_W-1:0] div;
  } gen_cfg_t;

  localparam gen_cfg_t CFG_OFF  = '{src: 4'd0, en: 1'b0, idc: 1'b0, oov: 1'b0,
                                    oe: 1'b0, divsel: 1'b0, div: '0};
  localparam gen_cfg_t CFG_BOOT = '{src: 4'd0, en: 1'b1, idc: 1'b0, oov: 1'b0,
                                    oe: 1'b0, divsel: 1'b0, div: '0};

  // full output period, counted in source ticks (two ticks per source period)
  function automatic logic [CKG_CNT_W-1:0] period_ticks(logic divsel, logic [CKG_DIV_W-1:0] div);
    int e;
    if (divsel) begin
      e = (int'(div) > CKG_DIV_W - 2) ? CKG_DIV_W - 2 : int'(div);
      return CKG_CNT_W'(1) << (e + 2);
    end
    if (div <= CKG_DIV_W'(1)) return CKG_CNT_W'(2);
    return {div, 1'b0};
  endfunction

  // ticks spent high inside one period
  function automatic logic [CKG_CNT_W-1:0] high_ticks(logic divsel, logic idc,
                                                      logic [CKG_DIV_W-1:0] div);
    if (divsel) return period_ticks(1'b1, div) >> 1;
    if (div <= CKG_DIV_W'(1)) return CKG_CNT_W'(1);
    if (idc || !div[0]) return {1'b0, div};
    return {1'b0, div} - CKG_CNT_W'(1);
  endfunction

  function automatic logic [31:0] pack_ctrl(logic [3:0] id, gen_cfg_t c, logic en_rd);
    logic [31:0] w;
    w        = '0;
    w[3:0]   = id;
    w[11:8]  = c.src;
    w[16]    = en_rd;
    w[17]    = c.idc;
    w[18]    = c.oov;
    w[19]    = c.oe;
    w[20]    = c.divsel;
    return w;
  endfunction

  function automatic logic [31:0] pack_div(logic [3:0] id, gen_cfg_t c);
    logic [31:0] w;
    w                  = '0;
    w[3:0]             = id;
    w[8 +: CKG_DIV_W]  = c.div;
    return w;
  endfunction
endpackage

// File: rtl/clkgen_regs.sv
module clkgen_regs
  import clkgen_pkg::*;
#(
  parameter int NGEN     = 4,
  parameter int SYNC_LAT = 4,
  localparam int IDW     = (NGEN > 1) ? $clog2(NGEN) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_we,
  input  logic [1:0]      bus_addr,
  input  logic [3:0]      bus_be,
  input  logic [31:0]     bus_wdata,
  input  logic [NGEN-1:0] running,
  output logic [31:0]     bus_rdata,
  output gen_cfg_t        act_cfg [NGEN],
  output logic [NGEN-1:0] apply,
  output logic            swrst_pulse,
  output logic            busy,
  output logic [IDW-1:0]  sel
);
  localparam int SW = $clog2(SYNC_LAT + 1);

  gen_cfg_t       shd [NGEN];
  logic [SW-1:0]  sync_cnt;
  logic           pend_rst;
  logic [IDW-1:0] pend_id;

  logic [3:0] wid;
  logic       wr_full, wr_byte, gen_addr, id_ok, sel_wr, cfg_wr, rst_wr, sync_end;
  logic       unused_bits;

  assign wid         = bus_wdata[3:0];
  assign wr_full     = bus_we && !busy && (bus_be == 4'hF);
  assign wr_byte     = bus_we && !busy && (bus_be == 4'h1);
  assign gen_addr    = (bus_addr == A_CTRL) || (bus_addr == A_DIV);
  assign id_ok       = int'(wid) < NGEN;
  assign sel_wr      = (wr_full || wr_byte) && gen_addr && id_ok;
  assign cfg_wr      = wr_full && gen_addr && id_ok;
  assign rst_wr      = wr_full && (bus_addr == A_MAIN) && bus_wdata[0];
  assign busy        = (sync_cnt != '0);
  assign sync_end    = (sync_cnt == SW'(1));
  assign swrst_pulse = sync_end && pend_rst;
  assign unused_bits = ^{bus_wdata[31:21], bus_wdata[15:12], bus_wdata[7:4]};

  for (genvar g = 0; g < NGEN; g++) begin : g_apply
    assign apply[g]   = sync_end && !pend_rst && (pend_id == IDW'(g));
    assign act_cfg[g] = act_q[g];
  end

  gen_cfg_t act_q [NGEN];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_cnt <= '0;
      pend_rst <= 1'b0;
      pend_id  <= '0;
      sel      <= '0;
      for (int g = 0; g < NGEN; g++) begin
        shd[g]   <= (g == 0) ? CFG_BOOT : CFG_OFF;
        act_q[g] <= (g == 0) ? CFG_BOOT : CFG_OFF;
      end
    end else if (swrst_pulse) begin
      sync_cnt <= '0;
      pend_rst <= 1'b0;
      pend_id  <= '0;
      sel      <= '0;
      for (int g = 0; g < NGEN; g++) begin
        shd[g]   <= (g == 0) ? CFG_BOOT : CFG_OFF;
        act_q[g] <= (g == 0) ? CFG_BOOT : CFG_OFF;
      end
    end else begin
      if (busy) sync_cnt <= sync_cnt - SW'(1);
      if (cfg_wr || rst_wr) begin
        sync_cnt <= SW'(SYNC_LAT);
        pend_rst <= rst_wr;
        pend_id  <= wid[IDW-1:0];
      end
      if (sel_wr) sel <= wid[IDW-1:0];
      for (int g = 0; g < NGEN; g++) begin
        if (cfg_wr && wid == 4'(g)) begin
          if (bus_addr == A_CTRL) begin
            shd[g].src    <= bus_wdata[11:8];
            shd[g].en     <= bus_wdata[16];
            shd[g].idc    <= bus_wdata[17];
            shd[g].oov    <= bus_wdata[18];
            shd[g].oe     <= bus_wdata[19];
            shd[g].divsel <= bus_wdata[20];
          end else begin
            shd[g].div <= bus_wdata[8 +: CKG_DIV_W];
          end
        end
        if (apply[g]) act_q[g] <= shd[g];
      end
    end
  end

  always_comb begin
    unique case (bus_addr)
      A_MAIN:  bus_rdata = {31'b0, busy && pend_rst};
      A_STAT:  bus_rdata = {31'b0, busy};
      A_CTRL:  bus_rdata = pack_ctrl(4'(sel), shd[sel], shd[sel].en | running[sel]);
      default: bus_rdata = pack_div(4'(sel), shd[sel]);
    endcase
  end
endmodule

// File: rtl/clkgen_div.sv
module clkgen_div
  import clkgen_pkg::*;
#(
  parameter int NSRC   = 4,
  parameter bit DEF_ON = 1'b0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            swrst,
  input  logic [NSRC-1:0] src_tick,
  input  gen_cfg_t        cfg,
  input  logic            apply,
  output logic            running,
  output logic            gen_clk,
  output logic            gen_pin
);
  logic [CKG_CNT_W-1:0] cnt_q, cnt_n, cnt_step, period, high;
  logic                 raw_q, raw_n, run_n, clk_n, tick, live;

  assign tick     = |(src_tick & (NSRC'(1) << cfg.src));
  assign period   = period_ticks(cfg.divsel, cfg.div);
  assign high     = high_ticks(cfg.divsel, cfg.idc, cfg.div);
  assign live     = cfg.en | running;
  assign cnt_step = (cnt_q >= period - CKG_CNT_W'(1)) ? '0 : cnt_q + CKG_CNT_W'(1);

  always_comb begin
    cnt_n = cnt_q;
    raw_n = raw_q;
    if (!live) begin
      cnt_n = '1;
      raw_n = 1'b0;
    end else if (tick) begin
      cnt_n = cnt_step;
      raw_n = (cnt_step < high);
    end
    run_n = running;
    if (!apply) begin
      if (cfg.en && !running && raw_n == cfg.oov)      run_n = 1'b1;
      else if (!cfg.en && running && raw_n == cfg.oov) run_n = 1'b0;
    end
    clk_n = run_n ? raw_n : cfg.oov;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '1;
      raw_q   <= 1'b0;
      running <= DEF_ON;
      gen_clk <= 1'b0;
    end else if (swrst) begin
      cnt_q   <= '1;
      raw_q   <= 1'b0;
      running <= DEF_ON;
      gen_clk <= 1'b0;
    end else begin
      cnt_q   <= cnt_n;
      raw_q   <= raw_n;
      running <= run_n;
      gen_clk <= clk_n;
    end
  end

  assign gen_pin = cfg.oe & gen_clk;
endmodule

// File: rtl/clkgen_bank.sv
module clkgen_bank
  import clkgen_pkg::*;
#(
  parameter int NGEN     = 4,
  parameter int NSRC     = 4,
  parameter int SYNC_LAT = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_tick,
  input  logic            bus_we,
  input  logic [1:0]      bus_addr,
  input  logic [3:0]      bus_be,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  output logic [NGEN-1:0] gen_clk,
  output logic [NGEN-1:0] gen_pin
);
  localparam int IDW = (NGEN > 1) ? $clog2(NGEN) : 1;

  gen_cfg_t        act_cfg [NGEN];
  logic [NGEN-1:0] apply_vec, running, oov_act;
  logic            swrst_pulse, busy;
  logic [IDW-1:0]  sel;

  clkgen_regs #(.NGEN(NGEN), .SYNC_LAT(SYNC_LAT)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .running(running), .bus_rdata(bus_rdata), .act_cfg(act_cfg),
    .apply(apply_vec), .swrst_pulse(swrst_pulse), .busy(busy), .sel(sel)
  );

  for (genvar g = 0; g < NGEN; g++) begin : g_gen
    assign oov_act[g] = act_cfg[g].oov;
    clkgen_div #(.NSRC(NSRC), .DEF_ON(g == 0)) u_div (
      .clk(clk), .rst_n(rst_n), .swrst(swrst_pulse), .src_tick(src_tick),
      .cfg(act_cfg[g]), .apply(apply_vec[g]), .running(running[g]),
      .gen_clk(gen_clk[g]), .gen_pin(gen_pin[g])
    );
  end
endmodule

// File: rtl/clkgen_bank_chk.sv
module clkgen_bank_chk #(
  parameter int NGEN = 4,
  parameter int IDW  = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            swrst_pulse,
  input logic [IDW-1:0]  sel,
  input logic [NGEN-1:0] running,
  input logic [NGEN-1:0] oov_act,
  input logic [NGEN-1:0] gen_clk
);
  // R8: no write lands while busy, so the selection cannot move
  p_sel_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !swrst_pulse) |=> $stable(sel));

  // R10: soft reset completion leaves only generator 0 running and clears busy
  p_swrst_defaults_r10: assert property (@(posedge clk) disable iff (!rst_n)
    swrst_pulse |=> (running == NGEN'(1)) && !busy);

  for (genvar g = 0; g < NGEN; g++) begin : g_chk
    // R11: a start or stop of the gate happens at the off level
    p_quiet_switch_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (running[g] != $past(running[g]) && $stable(oov_act[g])) |-> gen_clk[g] == oov_act[g]);

    // R7: a stopped generator sits at its off level
    p_off_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!running[g] && $stable(oov_act[g])) |-> gen_clk[g] == oov_act[g]);
  end
endmodule

bind clkgen_bank clkgen_bank_chk #(.NGEN(NGEN), .IDW(IDW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .swrst_pulse(swrst_pulse), .sel(sel),
  .running(running), .oov_act(oov_act), .gen_clk(gen_clk)
);

// File: tb/test_clkgen_bank.sv
module test_clkgen_bank;
  localparam int NGEN = 4;
  localparam int NSRC = 4;

  typedef struct {
    int    hi;
    int    lo;
    string tag;
  } wave_t;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NSRC-1:0] src_tick = '0;
  logic            bus_we = 1'b0;
  logic [1:0]      bus_addr = '0;
  logic [3:0]      bus_be = '0;
  logic [31:0]     bus_wdata = '0;
  logic [31:0]     bus_rdata;
  logic [NGEN-1:0] gen_clk, gen_pin;

  int total = 0, bad = 0, cyc = 0;
  bit finished = 1'b0;
  wave_t exp_q[$];
  wave_t act_q[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc++;

  // source 0 ticks every cycle, source 1 every third cycle
  always @(negedge clk) begin
    src_tick[0] = 1'b1;
    src_tick[1] = (cyc % 3 == 0);
  end

  clkgen_bank i_clkgen_bank (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .gen_clk(gen_clk), .gen_pin(gen_pin)
  );

  task automatic chk(bit ok, string tag, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [3:0] be, logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_be = '0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] v);
    bus_addr = a;
    #1 v = bus_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 100; i++) begin
      rd(2'd1, v);
      if (!v[0]) break;
      @(negedge clk);
    end
  endtask

  function automatic logic [31:0] ctrl_word(int id, int src, bit en, bit idc, bit oov, bit oe, bit pw);
    return 32'(id) | (32'(src) << 8) | (32'(en) << 16) | (32'(idc) << 17) |
           (32'(oov) << 18) | (32'(oe) << 19) | (32'(pw) << 20);
  endfunction

  task automatic cfg_gen(int id, int src, bit en, bit idc, bit oov, bit oe, bit pw, int dv);
    wait_idle();
    wr(2'd3, 4'hF, 32'(id) | (32'(dv) << 8));
    wait_idle();
    wr(2'd2, 4'hF, ctrl_word(id, src, en, idc, oov, oe, pw));
    wait_idle();
    repeat (40) @(negedge clk);
  endtask

  // expected waveform, restated from the requirements in cycles
  task automatic expect_int(int n, bit idc, int rate, string tag);
    wave_t w;
    if (n <= 1) begin w.hi = 1; w.lo = 1; end
    else if (idc || (n % 2 == 0)) begin w.hi = n; w.lo = n; end
    else begin w.hi = n - 1; w.lo = n + 1; end
    w.hi *= rate; w.lo *= rate; w.tag = tag;
    exp_q.push_back(w);
  endtask

  task automatic expect_pow(int e, string tag);
    wave_t w;
    w.hi = 2 ** (e + 1); w.lo = w.hi; w.tag = tag;
    exp_q.push_back(w);
  endtask

  task automatic measure(int g);
    wave_t w;
    logic  prev;
    w.hi = 0; w.lo = 0; w.tag = "";
    prev = gen_clk[g];
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (!prev && gen_clk[g]) break;
      prev = gen_clk[g];
    end
    w.hi = 1;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (gen_clk[g]) w.hi++; else break;
    end
    w.lo = 1;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (!gen_clk[g]) w.lo++; else break;
    end
    act_q.push_back(w);
  endtask

  // scoreboard monitor
  initial begin
    wave_t a, e;
    forever begin
      @(negedge clk);
      while (act_q.size() > 0) begin
        a = act_q.pop_front();
        if (exp_q.size() == 0) chk(1'b0, "scoreboard underflow", a.hi, 0);
        else begin
          e = exp_q.pop_front();
          chk(a.hi == e.hi, {e.tag, " high"}, a.hi, e.hi);
          chk(a.lo == e.lo, {e.tag, " low"}, a.lo, e.lo);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    bit          ok;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 defaults
    rd(2'd2, v);
    chk(v[3:0] == 0, "R1 selected id", int'(v[3:0]), 0);
    chk(v[16] == 1'b1, "R1 gen0 enabled", int'(v[16]), 1);
    chk(v[11:8] == 0, "R1 gen0 source", int'(v[11:8]), 0);
    chk(v[20] == 1'b0, "R1 gen0 integer mode", int'(v[20]), 0);
    rd(2'd3, v);
    chk(v[15:8] == 0, "R1 gen0 divide", int'(v[15:8]), 0);
    rd(2'd1, v);
    chk(v[0] == 1'b0, "R1 not busy", int'(v[0]), 0);

    // R5 pass-through on gen0
    expect_int(1, 1'b0, 1, "R5 pass-through");
    measure(0);

    // R2 byte select of gen2
    wr(2'd2, 4'h1, 32'd2);
    rd(2'd2, v);
    chk(v[3:0] == 2, "R2 ctrl id", int'(v[3:0]), 2);
    chk(v[16] == 1'b0, "R2 gen2 enable", int'(v[16]), 0);
    rd(2'd3, v);
    chk(v[3:0] == 2, "R2 div id", int'(v[3:0]), 2);

    // R7 disabled output and pin
    chk(gen_clk[2] == 1'b0, "R7 off level", int'(gen_clk[2]), 0);
    chk(gen_pin[2] == 1'b0, "R7 pin", int'(gen_pin[2]), 0);

    // R11 first pulse after enable, R3 odd divide
    wait_idle();
    wr(2'd3, 4'hF, 32'd1 | (32'd3 << 8));
    wait_idle();
    wr(2'd2, 4'hF, ctrl_word(1, 0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0));
    expect_int(3, 1'b0, 1, "R11 first pulse");
    measure(1);
    expect_int(3, 1'b0, 1, "R3 odd divide");
    measure(1);
    ok = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (gen_pin[1] != gen_clk[1]) ok = 1'b0;
    end
    chk(ok, "R7 pin follows clock", int'(ok), 1);

    // R4 duty improve
    cfg_gen(1, 0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 3);
    expect_int(3, 1'b1, 1, "R4 odd with duty improve");
    measure(1);

    // R3 even divide
    cfg_gen(1, 0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 4);
    expect_int(4, 1'b0, 1, "R3 even divide");
    measure(1);

    // R6 power mode
    cfg_gen(1, 0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 2);
    expect_pow(2, "R6 power e=2");
    measure(1);
    cfg_gen(1, 0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 0);
    expect_pow(0, "R6 power e=0");
    measure(1);

    // R9 enable reads 1 until stopped
    wr(2'd2, 4'hF, ctrl_word(1, 0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1));
    rd(2'd2, v);
    chk(v[16] == 1'b1, "R9 enable still reads 1", int'(v[16]), 1);
    wait_idle();
    ok = 1'b0;
    for (int i = 0; i < 50; i++) begin
      rd(2'd2, v);
      if (!v[16]) begin ok = 1'b1; break; end
      @(negedge clk);
    end
    chk(ok, "R9 enable clears after stop", int'(ok), 1);
    ok = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (gen_clk[1] != 1'b1 || gen_pin[1] != 1'b1) ok = 1'b0;
    end
    chk(ok, "R7 held at off level 1", int'(gen_clk[1]), 1);

    // R8 busy window
    wait_idle();
    wr(2'd2, 4'hF, ctrl_word(3, 0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0));
    rd(2'd1, v);
    chk(v[0] == 1'b1, "R8 busy after write", int'(v[0]), 1);
    wr(2'd3, 4'hF, 32'd3 | (32'd7 << 8));
    wait_idle();
    rd(2'd3, v);
    chk(v[15:8] == 0, "R8 write during busy ignored", int'(v[15:8]), 0);
    chk(v[3:0] == 3, "R8 selection kept", int'(v[3:0]), 3);
    expect_int(0, 1'b0, 1, "R8 applied after busy");
    measure(3);

    // R12 source select
    cfg_gen(2, 1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2);
    expect_int(2, 1'b0, 3, "R12 source 1");
    measure(2);

    // R10 soft reset
    wait_idle();
    wr(2'd0, 4'hF, 32'd1);
    rd(2'd0, v);
    chk(v[0] == 1'b1, "R10 reset pending", int'(v[0]), 1);
    wait_idle();
    rd(2'd0, v);
    chk(v[0] == 1'b0, "R10 reset self-clears", int'(v[0]), 0);
    rd(2'd2, v);
    chk(v[3:0] == 0 && v[16], "R10 gen0 selected and enabled", int'(v[16]), 1);
    wr(2'd2, 4'h1, 32'd1);
    rd(2'd2, v);
    chk(v[16] == 1'b0 && v[20] == 1'b0, "R10 gen1 back to default", int'(v[16]), 0);
    rd(2'd3, v);
    chk(v[15:8] == 0, "R10 gen1 divide default", int'(v[15:8]), 0);
    chk(gen_clk[1] == 1'b0, "R10 gen1 off level default", int'(gen_clk[1]), 0);
    expect_int(1, 1'b0, 1, "R10 gen0 runs after reset");
    measure(0);

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule